// File: doc/BRIEF.md
# Weighted Activity Counter with Streak Watermarks

This block measures how busy a monitored clock domain is. A single-bit activity input, already synchronous to the block clock, is sampled on every cycle. Each active cycle adds a programmable weight to an accumulator. The accumulator is kept in units of 1/256, so a weight of 256 adds exactly one count per active cycle.

The sample window is a period field multiplied by a tick length. The tick is 256 or 65536 reference cycles. At the end of each window the accumulated count is stored in a readable register and the accumulator restarts.

Each finished sample is compared against two programmable marks, one high and one low. An interrupt bit is set only after the required number of back-to-back samples, from 1 to 8, have fallen beyond a mark. When that happens, the hardware disarms that mark so software must re-arm it. Software drives the block through a 32-bit register port with one-cycle registered read data. The level interrupt is the OR of the status bits.

Top module: `act_mon`

## Requirements
- R1: With sampling running, each window of period×tick clocks produces a count of floor(sum of weights of active cycles / 256). The count is readable at offset 0x18 from the clock after the window ends. The weight is at offset 0x24 and the period is control bits 7:0.
- R2: Bit 2 of the register at offset 0x28 selects a tick of 65536 clocks when set and 256 clocks when clear.
- R3: The count saturates at 0xFFFFFFFF instead of wrapping.
- R4: With control bit 19 set, status bit 31 (offset 0x20) is set when control bits 28:26 plus one consecutive samples each exceed the high mark at offset 0x04.
- R5: With control bit 18 set, status bit 30 is set when control bits 23:21 plus one consecutive samples each fall below the low mark at offset 0x08.
- R6: A sample that does not pass a mark restarts that mark's streak from zero.
- R7: A firing mark clears its own enable bit (19 or 18) in the same clock. A mark whose enable bit is clear holds its streak at zero and never fires.
- R8: Writing 1 to a status bit clears it and writing 0 leaves it. A hardware set in the same clock wins over the clear.
- R9: irq_o is high exactly when any status bit is set, updated on the same clock edge as the status bits.
- R10: Sampling runs only while control bit 31 (enable) and bit 13 (periodic) are set and the period is nonzero. Otherwise the accumulator, tick counters and streaks are zero, and the count and all registers keep their values.
- R11: After reset every register reads zero and irq_o is low. reg_rdata returns the register at reg_addr one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and reference clock |
| rst | input | 1 | Synchronous active-high reset |
| act_i | input | 1 | Activity of the monitored domain, one per cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| irq_o | output | 1 | Level interrupt, OR of status bits |

## Verification
The bound checker watches several properties on every cycle:
- the interrupt level against the status bits;
- that the count moves only at a window end;
- that no window ends while sampling is stopped;
- that a firing mark was armed and disarms itself;
- that write-one-to-clear and hardware-set priority hold on the high status bit.

Only the bench scenarios can show the arithmetic and the counting:
- the weighted count values, including saturation;
- the tick length selection;
- the streak lengths that do or do not fire;
- that the count survives a stop.

// File: rtl/act_mon_pkg.sv
package act_mon_pkg;
  localparam logic [5:0] OFS_CTRL   = 6'h00;
  localparam logic [5:0] OFS_HIMARK = 6'h04;
  localparam logic [5:0] OFS_LOMARK = 6'h08;
  localparam logic [5:0] OFS_COUNT  = 6'h18;
  localparam logic [5:0] OFS_STAT   = 6'h20;
  localparam logic [5:0] OFS_WEIGHT = 6'h24;
  localparam logic [5:0] OFS_SCTRL  = 6'h28;

  localparam int BIT_STAT_HI = 31;
  localparam int BIT_STAT_LO = 30;
  localparam int BIT_LONG    = 2;

  typedef struct packed {
    logic       en;
    logic [2:0] hi_n;
    logic [2:0] lo_n;
    logic       hi_arm;
    logic       lo_arm;
    logic       periodic;
    logic [7:0] period;
  } ctrl_t;

  function automatic ctrl_t ctrl_from_word(input logic [31:0] w);
    ctrl_t c;
    c.en       = w[31];
    c.hi_n     = w[28:26];
    c.lo_n     = w[23:21];
    c.hi_arm   = w[19];
    c.lo_arm   = w[18];
    c.periodic = w[13];
    c.period   = w[7:0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_word(input ctrl_t c);
    logic [31:0] w;
    w        = '0;
    w[31]    = c.en;
    w[28:26] = c.hi_n;
    w[23:21] = c.lo_n;
    w[19]    = c.hi_arm;
    w[18]    = c.lo_arm;
    w[13]    = c.periodic;
    w[7:0]   = c.period;
    return w;
  endfunction
endpackage

// File: rtl/act_mon_tick.sv
module act_mon_tick #(
  parameter int PW         = 8,
  parameter int SHORT_LOG2 = 8,
  parameter int LONG_LOG2  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          long_sel,
  input  logic [PW-1:0] period,
  output logic          sample_end
);
  logic [LONG_LOG2-1:0] pre_q;
  logic [PW-1:0]        pc_q;
  logic                 tick_last;
  logic                 win_last;

  assign tick_last  = long_sel ? (&pre_q) : (&pre_q[SHORT_LOG2-1:0]);
  assign win_last   = (pc_q >= period - PW'(1));
  assign sample_end = run && tick_last && win_last;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      pc_q  <= '0;
    end else begin
      pre_q <= tick_last ? '0 : pre_q + 1'b1;
      if (tick_last) pc_q <= win_last ? '0 : pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/act_mon_accum.sv
module act_mon_accum #(
  parameter int DW   = 32,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          act,
  input  logic [DW-1:0] weight,
  input  logic          sample_end,
  output logic [DW-1:0] new_count,
  output logic [DW-1:0] count_q
);
  localparam int ACW = DW + FRAC;

  logic [ACW-1:0] acc_q;
  logic [ACW:0]   sum;
  logic [ACW-1:0] acc_nx;

  assign sum       = {1'b0, acc_q} + (act ? (ACW+1)'(weight) : '0);
  assign acc_nx    = sum[ACW] ? '1 : sum[ACW-1:0];
  assign new_count = acc_nx[ACW-1:FRAC];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      count_q <= '0;
    end else if (!run) begin
      acc_q <= '0;
    end else if (sample_end) begin
      acc_q   <= '0;
      count_q <= new_count;
    end else begin
      acc_q <= acc_nx;
    end
  end
endmodule

// File: rtl/act_mon_streak.sv
module act_mon_streak #(
  parameter int DW    = 32,
  parameter int NW    = 3,
  parameter bit ABOVE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          armed,
  input  logic          sample_end,
  input  logic [DW-1:0] count,
  input  logic [DW-1:0] mark,
  input  logic [NW-1:0] need,
  output logic          fire,
  output logic [NW-1:0] streak_q
);
  logic hit;

  generate
    if (ABOVE) begin : g_above
      assign hit = count > mark;
    end else begin : g_below
      assign hit = count < mark;
    end
  endgenerate

  assign fire = armed && sample_end && hit && (streak_q >= need);

  always_ff @(posedge clk) begin
    if (rst || !armed) begin
      streak_q <= '0;
    end else if (sample_end) begin
      if (!hit || fire) streak_q <= '0;
      else              streak_q <= streak_q + 1'b1;
    end
  end
endmodule

// File: rtl/act_mon.sv
module act_mon
  import act_mon_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 6,
  parameter int FRAC       = 8,
  parameter int SHORT_LOG2 = 8,
  parameter int LONG_LOG2  = 16,
  parameter int NW         = 3,
  parameter int PW         = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          act_i,
  input  logic          reg_we,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          irq_o
);
  localparam int NSIDE = 2;

  ctrl_t         ctrl_q, ctrl_nx;
  logic [DW-1:0] himark_q, lomark_q, weight_q, rdata_q;
  logic          long_q;
  logic [1:0]    status_q, status_nx, clr;
  logic          irq_q;
  logic          run, sample_end;
  logic [DW-1:0] new_count, count_q;
  logic [NSIDE-1:0] armed, fire;
  logic [NW-1:0] need   [NSIDE];
  logic [DW-1:0] mark   [NSIDE];
  logic [NW-1:0] streak [NSIDE];
  logic          wr_ctrl, wr_stat;

  assign wr_ctrl = reg_we && (reg_addr == AW'(OFS_CTRL));
  assign wr_stat = reg_we && (reg_addr == AW'(OFS_STAT));
  assign run     = ctrl_q.en && ctrl_q.periodic && (ctrl_q.period != '0);

  act_mon_tick #(.PW(PW), .SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_tick (
    .clk(clk), .rst(rst), .run(run), .long_sel(long_q),
    .period(ctrl_q.period), .sample_end(sample_end)
  );

  act_mon_accum #(.DW(DW), .FRAC(FRAC)) u_acc (
    .clk(clk), .rst(rst), .run(run), .act(act_i), .weight(weight_q),
    .sample_end(sample_end), .new_count(new_count), .count_q(count_q)
  );

  assign armed   = {ctrl_q.hi_arm, ctrl_q.lo_arm};
  assign need[1] = ctrl_q.hi_n;
  assign need[0] = ctrl_q.lo_n;
  assign mark[1] = himark_q;
  assign mark[0] = lomark_q;

  generate
    for (genvar s = 0; s < NSIDE; s++) begin : g_side
      act_mon_streak #(.DW(DW), .NW(NW), .ABOVE(s == 1)) u_streak (
        .clk(clk), .rst(rst), .armed(armed[s] && run),
        .sample_end(sample_end), .count(new_count), .mark(mark[s]),
        .need(need[s]), .fire(fire[s]), .streak_q(streak[s])
      );
    end
  endgenerate

  always_comb begin
    ctrl_nx = wr_ctrl ? ctrl_from_word(32'(reg_wdata)) : ctrl_q;
    if (fire[1]) ctrl_nx.hi_arm = 1'b0;
    if (fire[0]) ctrl_nx.lo_arm = 1'b0;
    clr       = wr_stat ? {reg_wdata[BIT_STAT_HI], reg_wdata[BIT_STAT_LO]} : 2'b00;
    status_nx = (status_q & ~clr) | fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      himark_q <= '0;
      lomark_q <= '0;
      weight_q <= '0;
      long_q   <= 1'b0;
      status_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_nx;
      status_q <= status_nx;
      irq_q    <= |status_nx;
      if (reg_we && reg_addr == AW'(OFS_HIMARK)) himark_q <= reg_wdata;
      if (reg_we && reg_addr == AW'(OFS_LOMARK)) lomark_q <= reg_wdata;
      if (reg_we && reg_addr == AW'(OFS_WEIGHT)) weight_q <= reg_wdata;
      if (reg_we && reg_addr == AW'(OFS_SCTRL))  long_q   <= reg_wdata[BIT_LONG];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= '0;
      case (reg_addr)
        AW'(OFS_CTRL):   rdata_q <= DW'(ctrl_to_word(ctrl_q));
        AW'(OFS_HIMARK): rdata_q <= himark_q;
        AW'(OFS_LOMARK): rdata_q <= lomark_q;
        AW'(OFS_COUNT):  rdata_q <= count_q;
        AW'(OFS_STAT):   rdata_q <= DW'({status_q, 30'b0});
        AW'(OFS_WEIGHT): rdata_q <= weight_q;
        AW'(OFS_SCTRL):  rdata_q <= DW'({long_q, 2'b00});
        default:         rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/act_mon_chk.sv
module act_mon_chk #(
  parameter int DW = 32,
  parameter int NW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          sample_end,
  input logic [DW-1:0] count,
  input logic [1:0]    status,
  input logic          irq,
  input logic          hi_arm,
  input logic [NW-1:0] hi_streak,
  input logic          clr_hi,
  input logic          fire_hi
);
  AST_IRQ_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
    irq == (|status)); // R9
  AST_COUNT_ONLY_AT_END: assert property (@(posedge clk) disable iff (rst)
    !sample_end |=> $stable(count)); // R1
  AST_NO_WINDOW_WHEN_STOPPED: assert property (@(posedge clk) disable iff (rst)
    !run |-> !sample_end); // R10
  AST_HI_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> $past(hi_arm)); // R4
  AST_FIRE_DISARMS: assert property (@(posedge clk) disable iff (rst)
    $rose(status[1]) |-> !hi_arm); // R7
  AST_UNARMED_STREAK_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hi_arm |=> hi_streak == '0); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (clr_hi && !fire_hi) |=> !status[1]); // R8
  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    fire_hi |=> status[1]); // R8
endmodule

bind act_mon act_mon_chk #(.DW(DW), .NW(NW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .sample_end(sample_end),
  .count(count_q), .status(status_q), .irq(irq_o),
  .hi_arm(ctrl_q.hi_arm), .hi_streak(streak[1]),
  .clr_hi(clr[1]), .fire_hi(fire[1])
);

// File: tb/act_mon_tb.sv
`timescale 1ns/1ps
module act_mon_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        act_i = 1'b0;
  logic        reg_we = 1'b0;
  logic [5:0]  reg_addr = 6'h18;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  longint unsigned wt = 0;
  logic [31:0] exp_q[$];
  event samp_done;
  logic [31:0] rd;

  always #5 clk = ~clk;

  act_mon u_dut (
    .clk(clk), .rst(rst), .act_i(act_i), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expv);
    checks++;
    if (actual !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, actual, expv);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    if (a == 6'h24) wt = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_addr = 6'h18;
  endtask

  task automatic rdreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); @(negedge clk);
    reg_addr = a;
    @(posedge clk); #2;
    d = reg_rdata;
    reg_addr = 6'h18;
  endtask

  // driver: one full window, pushes the expected count for the monitor
  task automatic run_sample(input int nact, input int len);
    longint unsigned v;
    v = (longint'(nact) * wt) >> 8;
    if (v > 64'hFFFF_FFFF) v = 64'hFFFF_FFFF;
    exp_q.push_back(v[31:0]);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); act_i = (i < nact);
      @(posedge clk);
    end
    ->samp_done;
    #1;
  endtask

  // monitor: pops expected counts when a window result appears
  initial begin
    forever begin
      @(samp_done);
      @(posedge clk); #2;
      if (exp_q.size() > 0) chk("R1 count", reg_rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11 reset state
    rdreg(6'h00, rd); chk("R11 ctrl reset", rd, 32'h0);
    rdreg(6'h18, rd); chk("R11 count reset", rd, 32'h0);
    chk("R11 irq reset", {31'b0, irq_o}, 32'h0);

    // R1 unit weight, several patterns
    wr(6'h24, 32'd256);
    wr(6'h00, 32'h8000_2001);
    run_sample(100, 256); run_sample(0, 256); run_sample(256, 256);
    wr(6'h00, 32'h0);
    // R1 other weights
    wr(6'h24, 32'd512); wr(6'h00, 32'h8000_2001);
    run_sample(100, 256); wr(6'h00, 32'h0);
    wr(6'h24, 32'd128); wr(6'h00, 32'h8000_2001);
    run_sample(101, 256); wr(6'h00, 32'h0);

    // R3 saturation: period 2, max weight
    wr(6'h24, 32'hFFFF_FFFF); wr(6'h00, 32'h8000_2002);
    run_sample(512, 512); wr(6'h00, 32'h0);

    // R10 stopped: activity ignored, count and registers kept
    wr(6'h04, 32'd150);
    wr(6'h00, 32'h8000_0001); // enable without periodic
    repeat (600) begin @(negedge clk); act_i = 1'b1; end
    @(negedge clk); act_i = 1'b0;
    rdreg(6'h18, rd); chk("R10 count kept", rd, 32'hFFFF_FFFF);
    rdreg(6'h04, rd); chk("R10 mark kept", rd, 32'd150);
    wr(6'h00, 32'h0);

    // R4/R6 high mark, two in a row needed
    wr(6'h24, 32'd256);
    wr(6'h00, 32'h8408_2001);
    run_sample(200, 256); chk("R4 one hit no irq", {31'b0, irq_o}, 32'h0);
    run_sample(100, 256); chk("R6 miss no irq", {31'b0, irq_o}, 32'h0);
    run_sample(200, 256); chk("R6 streak restarted", {31'b0, irq_o}, 32'h0);
    run_sample(200, 256); chk("R4 second hit irq", {31'b0, irq_o}, 32'h1);
    rdreg(6'h20, rd); chk("R4 status high bit", rd, 32'h8000_0000);
    rdreg(6'h00, rd); chk("R7 high arm cleared", rd, 32'h8400_2001);
    wr(6'h00, 32'h0);

    // R8/R9 clear all
    wr(6'h20, 32'hFFFF_FFFF);
    rdreg(6'h20, rd); chk("R8 cleared", rd, 32'h0);
    chk("R9 irq low", {31'b0, irq_o}, 32'h0);

    // R7 unarmed high mark never fires; R5 low mark single sample
    wr(6'h08, 32'd50);
    wr(6'h00, 32'h8004_2001);
    run_sample(200, 256); chk("R7 unarmed no fire", {31'b0, irq_o}, 32'h0);
    run_sample(10, 256);  chk("R5 low fires", {31'b0, irq_o}, 32'h1);
    rdreg(6'h20, rd); chk("R5 status low bit", rd, 32'h4000_0000);
    rdreg(6'h00, rd); chk("R7 low arm cleared", rd, 32'h8000_2001);
    wr(6'h00, 32'h0);

    // R8 selective clear with both bits set
    wr(6'h00, 32'h8008_2001);
    run_sample(200, 256);
    wr(6'h00, 32'h0);
    rdreg(6'h20, rd); chk("R8 both set", rd, 32'hC000_0000);
    wr(6'h20, 32'h8000_0000);
    rdreg(6'h20, rd); chk("R8 only high cleared", rd, 32'h4000_0000);
    chk("R9 irq still high", {31'b0, irq_o}, 32'h1);
    wr(6'h20, 32'hFFFF_FFFF);
    chk("R9 irq drops", {31'b0, irq_o}, 32'h0);

    // R2 long tick
    wr(6'h28, 32'h4);
    rdreg(6'h28, rd); chk("R2 tick select", rd, 32'h4);
    wr(6'h00, 32'h8000_2001);
    run_sample(65536, 65536);
    wr(6'h00, 32'h0);
    rdreg(6'h18, rd); chk("R2 long window count", rd, 32'd65536);

    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule